// File: doc/BRIEF.md
# Rail Startup Timer

This block times the startup of one switching supply rail. It counts switching-cycle ticks from the moment its rail is enabled and turns that single count into three milestones. The first is a soft-start current-limit code that climbs in equal steps from zero to full scale over the soft-start window. The second is an arming flag for under-voltage protection that rises once a longer delay has passed. The third is an active-low reset output that signals power-good only after the rail has stayed in regulation for a long hold-off.

The supervisor supplies the rail enable, a clear from its fault latch, the cycle tick from the oscillator divider and the in-regulation flag it has selected for this rail. Since every count advances on the tick, all delays scale with the switching frequency. The analog current limit and its converter sit outside the block: it only produces the digital step number.

Top module: `rail_startup_timer`

## Requirements
- R1: While reset is asserted and in the cycle after it, `ilim_step` is 0, `uv_arm` is 0 and `rail_rst_n` is 0.
- R2: With the rail active (`rail_en`=1 and `clear`=0), `ilim_step` equals the number of step indices k in 1..N_STEPS for which the tick count since enable, n, satisfies n*N_STEPS >= k*SOFT_CYCLES. Code value k stands for k/N_STEPS of full current limit, so it is 0 at enable and reaches k after ceil(k*SOFT_CYCLES/N_STEPS) ticks.
- R3: `ilim_step` never exceeds N_STEPS and holds N_STEPS from tick SOFT_CYCLES onward.
- R4: `uv_arm` rises after the UV_DELAY-th tick since enable and stays high while the rail stays active.
- R5: `rail_rst_n` stays low until PG_DELAY ticks have been counted with `in_reg` high throughout, and goes high after the PG_DELAY-th such tick.
- R6: `rail_rst_n` falls in the same cycle that `in_reg` goes low. When regulation returns, the full PG_DELAY tick count restarts from zero.
- R7: When `rail_en` is 0 or `clear` is 1, all three outputs are 0 in that same cycle and all counts restart from zero at the next enable.
- R8: Counts advance only in cycles where `tick` is 1; in other cycles `ilim_step` and `uv_arm` keep their values.
- R9: The soft-start and under-voltage counts advance regardless of `in_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_en | input | 1 | Rail enable; high runs the timers |
| clear | input | 1 | Fault-latch clear; high forces all counts to zero |
| tick | input | 1 | One-cycle pulse per switching cycle |
| in_reg | input | 1 | Selected in-regulation flag for this rail |
| ilim_step | output | $clog2(N_STEPS+1) | Soft-start current-limit step, 0 to N_STEPS |
| uv_arm | output | 1 | Under-voltage protection armed |
| rail_rst_n | output | 1 | Active-low reset, high means power good |

## Verification
A wrong soft-start count shows as a limit step that moves one or more ticks early or late against the threshold arithmetic, visible at the first boundary it crosses, and a wrong arming count shows as `uv_arm` rising on the wrong tick. A power-good counter that fails to restart on a regulation loss shows as `rail_rst_n` going high too soon after recovery, within the delay window. Stale state across a disable or clear shows as outputs that are nonzero in the clear cycle or that resume mid-ramp after re-enable, on the first tick.

// File: rtl/rail_timer_pkg.sv
// Package: shared helper functions for the rail startup timer.
// Assumes all arguments are positive integers small enough for int math.
package rail_timer_pkg;

    // Tick count at which soft-start step k is reached (rounded up).
    function automatic int step_at(input int k, input int span, input int steps);
        return (k * span + steps - 1) / steps;
    endfunction

    // Larger of two integers, used to size the shared run counter.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_sat_counter.sv
// Module: saturating tick counter with synchronous clear.
// Counts up on adv until LIMIT, then holds; clr wins over adv.
// Assumes LIMIT >= 1.
module rst_sat_counter #(
    parameter int LIMIT = 512,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         full
);

    localparam logic [W-1:0] TOP = W'(LIMIT);

    // Count register: reset, clear, or saturating advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (adv && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

    // Saturation flag.
    assign full = (count == TOP);

endmodule

// File: rtl/ilim_step_decode.sv
// Module: turns the run count into a soft-start current-limit step.
// One comparator per step against a rounded-up threshold; since the
// thresholds rise with k, the number of passed thresholds is the step.
// Assumes RW is wide enough to hold SOFT_CYCLES.
module ilim_step_decode
    import rail_timer_pkg::*;
#(
    parameter int SOFT_CYCLES = 512,
    parameter int N_STEPS     = 5,
    parameter int RW          = 13,
    parameter int CW          = $clog2(N_STEPS + 1)
) (
    input  logic [RW-1:0] run_count,
    output logic [CW-1:0] step
);

    logic [N_STEPS-1:0] passed;

    // One threshold comparator per step.
    for (genvar k = 1; k <= N_STEPS; k++) begin : g_thr
        localparam logic [RW-1:0] THR = RW'(step_at(k, SOFT_CYCLES, N_STEPS));
        assign passed[k-1] = (run_count >= THR);
    end

    // Population count of passed thresholds.
    always_comb begin
        step = '0;
        for (int i = 0; i < N_STEPS; i++) begin
            step = step + CW'(passed[i]);
        end
    end

endmodule

// File: rtl/rail_startup_timer.sv
// Module: per-rail startup timer. One run counter drives the soft-start
// step and the under-voltage arming; a second counter times the
// power-good hold-off and restarts on any loss of regulation.
// Assumes tick is a single-cycle pulse per switching cycle.
module rail_startup_timer
    import rail_timer_pkg::*;
#(
    parameter int SOFT_CYCLES = 512,
    parameter int N_STEPS     = 5,
    parameter int UV_DELAY    = 6144,
    parameter int PG_DELAY    = 32768,
    localparam int CW         = $clog2(N_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rail_en,
    input  logic          clear,
    input  logic          tick,
    input  logic          in_reg,
    output logic [CW-1:0] ilim_step,
    output logic          uv_arm,
    output logic          rail_rst_n
);

    localparam int RUN_LIMIT = imax(SOFT_CYCLES, UV_DELAY);
    localparam int RW        = $clog2(RUN_LIMIT + 1);
    localparam int PW        = $clog2(PG_DELAY + 1);
    localparam logic [RW-1:0] UV_AT = RW'(UV_DELAY);

    logic          active;
    logic [RW-1:0] run_count;
    logic          run_full;
    logic [PW-1:0] pg_count;
    logic          pg_full;
    logic [CW-1:0] step_raw;

    // Rail is running when enabled and not held by the fault latch.
    assign active = rail_en & ~clear;

    // Shared run counter for soft-start and under-voltage arming.
    rst_sat_counter #(.LIMIT(RUN_LIMIT), .W(RW)) u_run_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~active),
        .adv   (tick),
        .count (run_count),
        .full  (run_full)
    );

    // Power-good hold-off counter, restarted whenever regulation is lost.
    rst_sat_counter #(.LIMIT(PG_DELAY), .W(PW)) u_pg_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~active | ~in_reg),
        .adv   (tick),
        .count (pg_count),
        .full  (pg_full)
    );

    // Step decoder for the current-limit ramp.
    ilim_step_decode #(
        .SOFT_CYCLES (SOFT_CYCLES),
        .N_STEPS     (N_STEPS),
        .RW          (RW),
        .CW          (CW)
    ) u_step (
        .run_count (run_count),
        .step      (step_raw)
    );

    // Output gating: everything drops at once when the rail stops.
    always_comb begin
        ilim_step  = active ? step_raw : '0;
        uv_arm     = active && (run_count >= UV_AT);
        rail_rst_n = active && in_reg && pg_full;
    end

endmodule

// File: rtl/rail_startup_timer_chk.sv
// Module: assertion checker for the rail startup timer, bound below.
// Observes ports only.
module rail_startup_timer_chk #(
    parameter int N_STEPS = 5,
    parameter int CW      = $clog2(N_STEPS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rail_en,
    input logic          clear,
    input logic          tick,
    input logic          in_reg,
    input logic [CW-1:0] ilim_step,
    input logic          uv_arm,
    input logic          rail_rst_n
);

    logic run;
    assign run = rail_en && !clear;

    // Step never exceeds full scale.
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_step <= CW'(N_STEPS));

    // Step never falls while the rail keeps running.
    p_step_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || ilim_step >= $past(ilim_step)));

    // Arming is sticky while running.
    p_uv_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && uv_arm) |=> (!run || uv_arm));

    // Power good only while in regulation.
    p_pg_needs_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rail_rst_n |-> in_reg);

    // Stopped rail shows all outputs low.
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ilim_step == '0 && !uv_arm && !rail_rst_n));

    // No tick, no movement of the run-count outputs.
    p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (!run || ($stable(ilim_step) && $stable(uv_arm))));

endmodule

bind rail_startup_timer rail_startup_timer_chk #(.N_STEPS(N_STEPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rail_en    (rail_en),
    .clear      (clear),
    .tick       (tick),
    .in_reg     (in_reg),
    .ilim_step  (ilim_step),
    .uv_arm     (uv_arm),
    .rail_rst_n (rail_rst_n)
);

// File: tb/rail_startup_timer_bench.sv
module rail_startup_timer_bench;

    localparam int SOFT = 20;
    localparam int NST  = 5;
    localparam int UVD  = 40;
    localparam int PGD  = 60;
    localparam int CW   = $clog2(NST + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rail_en = 1'b0;
    logic          clear = 1'b0;
    logic          tick = 1'b0;
    logic          in_reg = 1'b0;
    logic [CW-1:0] ilim_step;
    logic          uv_arm;
    logic          rail_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    code;
        bit    uv;
        bit    pg;
        string tag;
    } exp_t;

    exp_t q[$];

    // Bench model state
    int m_run = 0;
    int m_pg  = 0;

    always #2.5 clk = ~clk;

    rail_startup_timer #(
        .SOFT_CYCLES (SOFT),
        .N_STEPS     (NST),
        .UV_DELAY    (UVD),
        .PG_DELAY    (PGD)
    ) u_rail_startup_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_en    (rail_en),
        .clear      (clear),
        .tick       (tick),
        .in_reg     (in_reg),
        .ilim_step  (ilim_step),
        .uv_arm     (uv_arm),
        .rail_rst_n (rail_rst_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic step(input bit en, input bit clr, input bit tk, input bit rg,
                        input string tag);
        exp_t e;
        int lim;
        @(negedge clk);
        rail_en = en; clear = clr; tick = tk; in_reg = rg;
        lim = (SOFT > UVD) ? SOFT : UVD;
        if (!en || clr) begin
            m_run = 0; m_pg = 0;
        end else begin
            if (tk && m_run < lim) m_run++;
            if (!rg) m_pg = 0;
            else if (tk && m_pg < PGD) m_pg++;
        end
        e.code = 0;
        if (en && !clr)
            for (int k = 1; k <= NST; k++)
                if (m_run * NST >= k * SOFT) e.code++;
        e.uv  = en && !clr && (m_run >= UVD);
        e.pg  = en && !clr && rg && (m_pg >= PGD);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge, away from it.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " ilim_step"}, int'(ilim_step), e.code);
            check({e.tag, " uv_arm"}, int'(uv_arm), int'(e.uv));
            check({e.tag, " rail_rst_n"}, int'(rail_rst_n), int'(e.pg));
        end
    end

    initial begin
        // R1: reset state, with inputs asserted
        rail_en = 1'b1; in_reg = 1'b1; tick = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset ilim_step", int'(ilim_step), 0);
        check("R1 reset uv_arm", int'(uv_arm), 0);
        check("R1 reset rail_rst_n", int'(rail_rst_n), 0);
        @(negedge clk);
        rail_en = 1'b0; tick = 1'b0;
        rst_n = 1'b1;
        step(0, 0, 0, 1, "R1 post-reset");

        // R2 R3 R4 R5: full ramp with a tick every cycle
        for (int i = 0; i < 70; i++) step(1, 0, 1, 1, "R2 R3 R4 R5 ramp");

        // R6: one-cycle regulation loss, then full restart of the delay
        step(1, 0, 1, 0, "R6 drop");
        for (int i = 0; i < 65; i++) step(1, 0, 1, 1, "R6 recover");

        // R7: disable clears, then ramp again with sparse ticks (R8)
        step(0, 0, 1, 1, "R7 disable");
        for (int i = 0; i < 90; i++) step(1, 0, (i % 3) == 0, 1, "R8 sparse ticks");

        // R7: fault clear mid-ramp then resume from zero
        for (int i = 0; i < 10; i++) step(1, 0, 1, 1, "R7 pre-clear");
        step(1, 1, 1, 1, "R7 clear");
        for (int i = 0; i < 12; i++) step(1, 0, 1, 1, "R7 after clear");

        // R9: out of regulation throughout, ramp and arming still proceed
        step(0, 0, 0, 0, "R9 idle");
        for (int i = 0; i < 50; i++) step(1, 0, 1, 0, "R9 no regulation");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 1, "R8 hold no tick");

        step(0, 0, 0, 0, "R7 final");
        @(posedge clk); #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule